// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit MAC from frames that software has placed in system memory. Software builds a ring of 8-byte descriptors. Each descriptor hands one data buffer to the block through its Ready bit. Software then writes the ring base and pulses the activate strobe while the global enable is high. The block fetches descriptors in ring order and reads each buffer through a 32-bit memory master port. It sends the buffer bytes out as a byte stream with a start-of-frame marker. It then writes the descriptor back with Ready cleared and moves to the next slot.

A frame may be spread over several descriptors. It ends at the first descriptor whose Last bit is set. The block counts the bytes of the frame in progress and never sends more than the frame cap. When a buffer would push the frame past the cap, the block sends only the bytes that fit and raises a babble event. The walk halts at the first descriptor that is not Ready and keeps that slot as its position. A later activate strobe resumes from there.

Top module: `tx_desc_engine`

## Requirements
- R1: A descriptor takes two 32-bit words at an 8-byte aligned address. The first word holds the flags in bits 31:16 and the buffer length in bits 15:0. The second word, at offset 4, is the byte address of the buffer. In the flags, bit 15 is Ready, bit 13 is Wrap and bit 11 is Last.
- R2: An activate strobe starts a walk only while `cfg_enable` is high. An activate strobe with `cfg_enable` low issues no memory request.
- R3: A walk ends at the first descriptor read with Ready clear. Only that descriptor's first word is read, and its address becomes the start of the next walk.
- R4: Each buffer is read as aligned words. Its bytes are sent on `tx_data` most-significant byte first, one per `tx_valid` cycle, starting at the byte lane given by the low two bits of the buffer address. Exactly the buffer length is sent, subject to R7. `tx_sof` is high with the first byte of each frame.
- R5: A frame continues across descriptors until one with Last set is written back. In the cycle after that write completes, `tx_eof` and `ev_tx_frame` pulse for one cycle with `tx_valid` low, and the frame byte count returns to zero.
- R6: Each consumed descriptor gets one write of its first word, to its own address. The written flags have bit 15 cleared and all other flag and length bits unchanged. `ev_tx_buf` pulses once for each such write.
- R7: No frame carries more than MAX_FRAME (default 2032) bytes. When a buffer does not fit in the remaining room, only the bytes that fit are sent, and `ev_babble` pulses together with that descriptor's `ev_tx_buf`.
- R8: After a write-back, the next descriptor is at the ring base if Wrap was set, and at the current address plus 8 otherwise.
- R9: A ring-base write stores the value with bits 1:0 forced to zero and moves the descriptor position to that base. When the write and an activate strobe fall in the same cycle, the walk starts from the new base.
- R10: An activate strobe that arrives while a walk is in progress (`walking` high) has no effect.
- R11: The block has at most one memory request outstanding. `mem_req` stays high with its address, direction and write data unchanged until the cycle `mem_rsp` is high, and every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global enable; gates activate |
| cfg_base_wr | input | 1 | Ring-base write strobe |
| cfg_base_data | input | 32 | Ring-base write value |
| cfg_activate | input | 1 | Transmit activate strobe |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp | input | 1 | Request complete this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_rsp |
| tx_valid | output | 1 | Byte valid on tx_data |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | End-of-frame strobe |
| ev_tx_buf | output | 1 | Descriptor consumed |
| ev_tx_frame | output | 1 | Frame completed |
| ev_babble | output | 1 | Frame cut at the cap |
| walking | output | 1 | Walk in progress |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the end of a walk and an activate strobe. The bench memory model watches for the read of a slot that is known to be not Ready. It raises `cfg_activate` in the same cycle as that read's response. The bench then requires that no further memory request appears, because the strobe was sampled while the walk was still running.

The second pair is a ring-base write and an activate strobe on the same edge. The bench judges this case by the address of the first descriptor read, which must be the new, aligned base. Random rings with random latency and activate strobes in the middle of a walk are compared byte for byte against a reference walk computed in the bench.

// File: rtl/tde_pkg.sv
package tde_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLAGS = 3'd1,
        ST_BUFA  = 3'd2,
        ST_DATA  = 3'd3,
        ST_EMIT  = 3'd4,
        ST_WBACK = 3'd5
    } tde_state_e;

    // flag bit positions inside the 16-bit descriptor flags half-word
    localparam int unsigned FLG_READY = 15;
    localparam int unsigned FLG_WRAP  = 13;
    localparam int unsigned FLG_LAST  = 11;
endpackage

// File: rtl/tde_cap_calc.sv
module tde_cap_calc #(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned CNT_W     = 11,
    parameter int unsigned MAX_FRAME = 2032
) (
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] fcnt,
    output logic [LEN_W-1:0] take,
    output logic             cut
);
    localparam int unsigned SW = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;

    logic [SW-1:0] room;
    logic [SW-1:0] len_x;

    always_comb begin
        room  = SW'(MAX_FRAME) - SW'(fcnt);
        len_x = SW'(len);
        cut   = len_x > room;
        take  = cut ? LEN_W'(room) : len;
    end
endmodule

// File: rtl/tde_lane_pick.sv
module tde_lane_pick #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0]              word,
    input  logic [$clog2(DW/8)-1:0]    lane,
    output logic [7:0]                 byte_out
);
    localparam int unsigned LANES = DW / 8;

    logic [7:0] lanes [LANES];

    // lane 0 is the most significant byte of the word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[DW-1-8*g -: 8];
    end

    assign byte_out = lanes[lane];
endmodule

// File: rtl/tde_ring_next.sv
module tde_ring_next #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          wrap,
    output logic [AW-1:0] nxt
);
    assign nxt = wrap ? base : cur + AW'(STEP);
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
    parameter int unsigned AW        = 32,
    parameter int unsigned MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_base_wr,
    input  logic [AW-1:0] cfg_base_data,
    input  logic          cfg_activate,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rsp,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_sof,
    output logic          tx_eof,
    output logic          ev_tx_buf,
    output logic          ev_tx_frame,
    output logic          ev_babble,
    output logic          walking
);
    import tde_pkg::*;

    localparam int unsigned DW         = 32;
    localparam int unsigned LEN_W      = DW / 2;
    localparam int unsigned LANE_W     = $clog2(DW / 8);
    localparam int unsigned CNT_W      = $clog2(MAX_FRAME + 1);
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned WORD_BYTES = DW / 8;

    typedef struct packed {
        tde_state_e        st;
        logic [AW-1:0]     base;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     waddr;
        logic [LEN_W-1:0]  flags;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  left;
        logic [CNT_W-1:0]  fcnt;
        logic [LANE_W-1:0] lane;
        logic [DW-1:0]     word;
        logic              cut;
        logic              req;
        logic              we;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic              tx_valid;
        logic [7:0]        tx_data;
        logic              sof;
        logic              eof;
        logic              ev_buf;
        logic              ev_frame;
        logic              ev_bab;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0] take_w;
    logic             cut_w;
    logic [7:0]       pick_w;
    logic [AW-1:0]    next_ptr_w;
    logic [AW-1:0]    base_new_w;
    logic [DW-1:0]    wb_word_w;
    logic             start_w;

    tde_cap_calc #(
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W),
        .MAX_FRAME(MAX_FRAME)
    ) u_cap (
        .len (mem_rdata[LEN_W-1:0]),
        .fcnt(q.fcnt),
        .take(take_w),
        .cut (cut_w)
    );

    tde_lane_pick #(.DW(DW)) u_pick (
        .word    (q.word),
        .lane    (q.lane),
        .byte_out(pick_w)
    );

    tde_ring_next #(.AW(AW), .STEP(DESC_BYTES)) u_next (
        .cur (q.ptr),
        .base(q.base),
        .wrap(q.flags[FLG_WRAP]),
        .nxt (next_ptr_w)
    );

    assign base_new_w = cfg_base_data & ~AW'(WORD_BYTES - 1);
    assign wb_word_w  = {q.flags & ~(LEN_W'(1) << FLG_READY), q.len};
    assign start_w    = cfg_activate && cfg_enable && (q.st == ST_IDLE);

    always_comb begin
        d          = q;
        d.tx_valid = 1'b0;
        d.sof      = 1'b0;
        d.eof      = 1'b0;
        d.ev_buf   = 1'b0;
        d.ev_frame = 1'b0;
        d.ev_bab   = 1'b0;

        if (cfg_base_wr) begin
            d.base = base_new_w;
            d.ptr  = base_new_w;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start_w) begin
                    d.st   = ST_FLAGS;
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = cfg_base_wr ? base_new_w : q.ptr;
                end
            end
            ST_FLAGS: begin
                if (mem_rsp) begin
                    d.flags = mem_rdata[DW-1:LEN_W];
                    d.len   = mem_rdata[LEN_W-1:0];
                    if (!mem_rdata[LEN_W + FLG_READY]) begin
                        d.st  = ST_IDLE;
                        d.req = 1'b0;
                    end else begin
                        d.left = take_w;
                        d.cut  = cut_w;
                        d.st   = ST_BUFA;
                        d.addr = q.ptr + AW'(WORD_BYTES);
                    end
                end
            end
            ST_BUFA: begin
                if (mem_rsp) begin
                    d.waddr = AW'(mem_rdata) & ~AW'(WORD_BYTES - 1);
                    d.lane  = mem_rdata[LANE_W-1:0];
                    if (q.left == '0) begin
                        d.st    = ST_WBACK;
                        d.we    = 1'b1;
                        d.addr  = q.ptr;
                        d.wdata = wb_word_w;
                    end else begin
                        d.st   = ST_DATA;
                        d.addr = AW'(mem_rdata) & ~AW'(WORD_BYTES - 1);
                    end
                end
            end
            ST_DATA: begin
                if (mem_rsp) begin
                    d.word = mem_rdata;
                    d.req  = 1'b0;
                    d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                d.tx_valid = 1'b1;
                d.tx_data  = pick_w;
                d.sof      = (q.fcnt == '0);
                d.fcnt     = q.fcnt + CNT_W'(1);
                d.left     = q.left - LEN_W'(1);
                if (q.left == LEN_W'(1)) begin
                    d.st    = ST_WBACK;
                    d.req   = 1'b1;
                    d.we    = 1'b1;
                    d.addr  = q.ptr;
                    d.wdata = wb_word_w;
                end else if (q.lane == LANE_W'(WORD_BYTES - 1)) begin
                    d.lane  = '0;
                    d.waddr = q.waddr + AW'(WORD_BYTES);
                    d.st    = ST_DATA;
                    d.req   = 1'b1;
                    d.we    = 1'b0;
                    d.addr  = q.waddr + AW'(WORD_BYTES);
                end else begin
                    d.lane = q.lane + LANE_W'(1);
                end
            end
            ST_WBACK: begin
                if (mem_rsp) begin
                    d.ev_buf = 1'b1;
                    d.ev_bab = q.cut;
                    if (q.flags[FLG_LAST]) begin
                        d.ev_frame = 1'b1;
                        d.eof      = 1'b1;
                        d.fcnt     = '0;
                    end
                    d.ptr  = next_ptr_w;
                    d.st   = ST_FLAGS;
                    d.we   = 1'b0;
                    d.addr = next_ptr_w;
                end
            end
            default: begin
                d.st  = ST_IDLE;
                d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req     = q.req;
    assign mem_we      = q.we;
    assign mem_addr    = q.addr;
    assign mem_wdata   = q.wdata;
    assign tx_valid    = q.tx_valid;
    assign tx_data     = q.tx_data;
    assign tx_sof      = q.sof;
    assign tx_eof      = q.eof;
    assign ev_tx_buf   = q.ev_buf;
    assign ev_tx_frame = q.ev_frame;
    assign ev_babble   = q.ev_bab;
    assign walking     = (q.st != ST_IDLE);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R6
    wb_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[LEN_W + FLG_READY]);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fcnt <= CNT_W'(MAX_FRAME));

    // R4
    sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> tx_valid);

    // R5
    eof_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |-> (!tx_valid && ev_tx_buf));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !walking |-> !mem_req);
endmodule

// File: tb/tb_tx_desc_engine.sv
`timescale 1ns/1ps
module tb_tx_desc_engine;
    localparam int MAXF = 2032;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_base_wr = 1'b0;
    logic [31:0] cfg_base_data = '0;
    logic        act_task = 1'b0;
    logic        act_hook = 1'b0;
    logic        cfg_activate;
    logic        mem_req, mem_we, mem_rsp;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_sof, tx_eof, ev_tx_buf, ev_tx_frame, ev_babble, walking;
    logic [7:0]  tx_data;

    assign cfg_activate = act_task | act_hook;

    always #2 clk = ~clk;

    tx_desc_engine #(.AW(32), .MAX_FRAME(MAXF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base_wr(cfg_base_wr),
        .cfg_base_data(cfg_base_data), .cfg_activate(cfg_activate),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .ev_tx_buf(ev_tx_buf), .ev_tx_frame(ev_tx_frame), .ev_babble(ev_babble),
        .walking(walking)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] mem     [0:4095];
    logic [31:0] ref_mem [0:4095];

    // memory model state
    bit          rsp_now = 0;
    int          wait_cnt = 0;
    int          reqs = 0;
    bit          first_seen = 0;
    logic [31:0] first_addr = '0;
    bit          hook_on = 0;
    logic [31:0] hook_addr = '0;

    // monitor
    logic [7:0] got_b[$];
    bit         got_s[$];
    int g_eof = 0, g_txb = 0, g_txf = 0, g_bab = 0;

    // reference
    logic [7:0]  exp_b[$];
    bit          exp_s[$];
    int e_txb = 0, e_txf = 0, e_bab = 0;
    logic [31:0] exp_base = '0;
    logic [31:0] exp_ptr = '0;
    int          exp_fcnt = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    initial mem_rsp = 1'b0;
    initial mem_rdata = '0;

    always @(negedge clk) begin
        if (rsp_now) begin
            rsp_now  = 0;
            mem_rsp  = 1'b0;
            act_hook = 1'b0;
        end else if (rst_n && mem_req) begin
            if (wait_cnt == 0) begin
                if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[13:2]];
                if (!mem_we && hook_on && mem_addr == hook_addr) act_hook = 1'b1;
                if (!first_seen) begin
                    first_seen = 1;
                    first_addr = mem_addr;
                end
                reqs++;
                mem_rsp  = 1'b1;
                rsp_now  = 1;
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt--;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                got_b.push_back(tx_data);
                got_s.push_back(tx_sof);
            end
            if (tx_eof) g_eof++;
            if (ev_tx_buf) g_txb++;
            if (ev_tx_frame) g_txf++;
            if (ev_babble) g_bab++;
        end
    end

    function automatic logic [7:0] ref_byte(input logic [31:0] a);
        logic [31:0] w;
        w = ref_mem[a[13:2]];
        return w[31 - 8*a[1:0] -: 8];
    endfunction

    // reference ring walk, written from the requirements
    task automatic model_walk();
        logic [31:0] p, w0, ba;
        int len, room, take;
        bit cut;
        p = exp_ptr;
        for (int guard = 0; guard < 64; guard++) begin
            w0 = ref_mem[p[13:2]];
            if (!w0[31]) break;
            len  = w0[15:0];
            ba   = ref_mem[p[13:2] + 1];
            room = MAXF - exp_fcnt;
            cut  = len > room;
            take = cut ? room : len;
            for (int i = 0; i < take; i++) begin
                exp_b.push_back(ref_byte(ba + i));
                exp_s.push_back(exp_fcnt == 0);
                exp_fcnt++;
            end
            ref_mem[p[13:2]] = w0 & ~32'h8000_0000;
            e_txb++;
            if (cut) e_bab++;
            if (w0[16 + 11]) begin
                e_txf++;
                exp_fcnt = 0;
            end
            p = w0[16 + 13] ? exp_base : p + 8;
        end
        exp_ptr = p;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [15:0] fl,
                            input logic [15:0] ln, input logic [31:0] ba);
        mem[a[13:2]]     = {fl, ln};
        mem[a[13:2] + 1] = ba;
    endtask

    task automatic wr_base(input logic [31:0] v);
        @(negedge clk);
        cfg_base_wr = 1'b1;
        cfg_base_data = v;
        @(negedge clk);
        cfg_base_wr = 1'b0;
        exp_base = v & ~32'h3;
        exp_ptr  = exp_base;
    endtask

    task automatic run_walk(input string tag, input bit mid_act, input bit with_base,
                            input logic [31:0] bval);
        int mism;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        if (with_base) begin
            exp_base = bval & ~32'h3;
            exp_ptr  = exp_base;
        end
        exp_b.delete(); exp_s.delete();
        e_txb = 0; e_txf = 0; e_bab = 0;
        model_walk();
        got_b.delete(); got_s.delete();
        g_eof = 0; g_txb = 0; g_txf = 0; g_bab = 0;
        first_seen = 0;
        @(negedge clk);
        cfg_enable = 1'b1;
        act_task = 1'b1;
        if (with_base) begin
            cfg_base_wr = 1'b1;
            cfg_base_data = bval;
        end
        @(negedge clk);
        act_task = 1'b0;
        cfg_base_wr = 1'b0;
        if (mid_act) begin
            repeat ($urandom % 6) @(negedge clk);
            if (walking) begin
                act_task = 1'b1;
                @(negedge clk);
                act_task = 1'b0;
            end
        end
        while (walking) @(negedge clk);
        repeat (4) @(negedge clk);

        mism = 0;
        if (got_b.size() != exp_b.size()) mism = 1;
        else for (int i = 0; i < exp_b.size(); i++) if (got_b[i] !== exp_b[i]) mism++;
        chk(mism == 0, {"R4 bytes ", tag}, got_b.size(), exp_b.size());
        mism = 0;
        if (got_s.size() != exp_s.size()) mism = 1;
        else for (int i = 0; i < exp_s.size(); i++) if (got_s[i] !== exp_s[i]) mism++;
        chk(mism == 0, {"R4 sof ", tag}, mism, 0);
        chk(g_txb == e_txb, {"R6 ev_tx_buf count ", tag}, g_txb, e_txb);
        chk(g_txf == e_txf && g_eof == e_txf, {"R5 frame/eof count ", tag}, g_txf * 256 + g_eof, e_txf * 257);
        chk(g_bab == e_bab, {"R7 babble count ", tag}, g_bab, e_bab);
        mism = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk(mism == 0, {"R6 write-back image ", tag}, mism, 0);
    endtask

    initial begin
        int watchdog;
        watchdog = 0;
        forever begin
            @(posedge clk);
            watchdog++;
            if (watchdog > 190000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4096; i++) mem[i] = (i >= 512) ? $urandom : 32'h0;

        repeat (3) @(negedge clk);
        chk(!mem_req && !tx_valid && !tx_eof && !walking, "R11 reset idle", {mem_req, tx_valid, tx_eof, walking}, 0);
        chk(!ev_tx_buf && !ev_tx_frame && !ev_babble && !tx_sof, "R6 reset events", {ev_tx_buf, ev_tx_frame, ev_babble}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: activate with enable low
        reqs = 0;
        cfg_enable = 1'b0;
        act_task = 1'b1;
        @(negedge clk);
        act_task = 1'b0;
        repeat (20) @(negedge clk);
        chk(reqs == 0 && !walking, "R2 disabled activate", reqs, 0);

        // R9: base write with unaligned value
        wr_base(32'h0000_0103);
        set_desc(32'h100, 16'h8000, 16'd5, 32'h801);
        set_desc(32'h108, 16'h8800, 16'd6, 32'h90A);
        set_desc(32'h110, 16'h0000, 16'd0, 32'h0);
        run_walk("two-part frame", 0, 0, 0);
        chk(first_addr == 32'h100, "R9 aligned base start", first_addr, 32'h100);
        chk(got_b.size() == 11, "R1 byte total", got_b.size(), 11);

        // R3: resume at the halted slot; R8: wrap to base
        set_desc(32'h110, 16'hA800, 16'd3, 32'hA03);
        run_walk("resume+wrap", 0, 0, 0);
        chk(first_addr == 32'h110, "R3 resume address", first_addr, 32'h110);
        set_desc(32'h100, 16'h8800, 16'd2, 32'hB00);
        run_walk("after wrap", 0, 0, 0);
        chk(first_addr == 32'h100, "R8 wrap start", first_addr, 32'h100);

        // random rings
        for (int r = 0; r < 8; r++) begin
            int n, k;
            logic [15:0] fl;
            wr_base(32'h200);
            n = 1 + $urandom % 6;
            k = $urandom % (n + 1);
            for (int i = 0; i < n; i++) begin
                fl = 16'($urandom) & 16'h57FF;
                if (i < k) fl[15] = 1'b1;
                if (i == n - 1 || ($urandom % 2)) fl[11] = 1'b1;
                if (i == n - 1) fl[13] = 1'b1;
                set_desc(32'h200 + 8 * i, fl, 16'($urandom % 41), 32'h800 + 32'h80 * i + ($urandom % 4));
            end
            run_walk("random ring", 1, 0, 0);
        end

        // R7: frame cap
        wr_base(32'h300);
        set_desc(32'h300, 16'h8000, 16'd1000, 32'h1000);
        set_desc(32'h308, 16'h8000, 16'd1000, 32'h1001);
        set_desc(32'h310, 16'h8800, 16'd100, 32'h1002);
        set_desc(32'h318, 16'h0000, 16'd0, 32'h0);
        run_walk("frame cap", 0, 0, 0);
        chk(g_bab == 1, "R7 babble seen", g_bab, 1);

        // R10: activate in the same cycle the walk halts
        wr_base(32'h600);
        set_desc(32'h600, 16'h8800, 16'd4, 32'h900);
        set_desc(32'h608, 16'h0000, 16'd0, 32'h0);
        hook_on = 1;
        hook_addr = 32'h608;
        run_walk("halt collision", 0, 0, 0);
        hook_on = 0;
        reqs = 0;
        repeat (20) @(negedge clk);
        chk(reqs == 0 && !walking, "R10 activate at halt ignored", reqs, 0);

        // R9: base write and activate in the same cycle
        set_desc(32'h680, 16'h8800, 16'd3, 32'h950);
        set_desc(32'h688, 16'h0000, 16'd0, 32'h0);
        run_walk("base+activate", 0, 1, 32'h683);
        chk(first_addr == 32'h680, "R9 same-cycle base", first_addr, 32'h680);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule